// File: doc/BRIEF.md
# Condition Register Field Hazard Scoreboard

This block lets independent condition-register instructions overlap in flight. Every instruction arrives with a 9-bit read vector and a 9-bit write vector. Bit n, for n from 0 to 7, stands for condition field CRn. Bit 8 says that the instruction touches the register as a whole.

An instruction that works on single fields, such as a CR logical operation, sets the bits of the fields it reads and writes, and also sets bit 8. An instruction that moves the entire register sets all nine bits.

The scoreboard keeps the pending field writes of up to four in-flight instructions. It decides combinationally whether a new instruction may issue, and names the slot that the instruction will occupy. On a completion pulse it releases that slot.

Bit 8 takes no part in the hazard decision. A hazard exists only when field bits 0 to 7 of the new instruction, read or write, overlap the pending field writes of a held slot.

Each slot is a small state machine with two states, SLOT_FREE and SLOT_HELD.
- The ALLOCATE transition moves a slot from SLOT_FREE to SLOT_HELD when an accepted issue selects it, and latches the field bits of the write vector.
- The RETIRE transition moves a slot from SLOT_HELD back to SLOT_FREE when a completion names it.
- In every other case the slot stays where it is.

All state changes on the rising clock edge. A synchronous active-low reset returns every slot to SLOT_FREE.

Top module: `cr_hzd_sb`

## Requirements
- R1: After reset every slot is free: `iss_ok` is 1 for any vectors and `iss_slot` is 0.
- R2: Issue is refused (`iss_ok`=0) when a field bit (0..7) of `iss_rd_vec` is also a pending write field of a held slot.
- R3: Issue is refused when a field bit of `iss_wr_vec` is a pending write field of a held slot, so no field is pending in two slots at once.
- R4: Bit 8 never causes a refusal: instructions whose vectors share only bit 8 issue together.
- R5: A held whole-register write (all nine write bits set) blocks every later instruction that names any field bit.
- R6: Only writes are recorded. A held slot whose write vector has no field bits blocks nothing, even when those fields were read.
- R7: `iss_slot` names the lowest-numbered free slot. The instruction is recorded there at the clock edge where `iss_req` and `iss_ok` are both 1.
- R8: With all four slots held, `iss_ok` is 0 even when there is no field overlap.
- R9: A completion (`cmp_valid`=1, `cmp_slot`=k) frees slot k at that edge. From the next cycle the slot is allocatable and its fields no longer block.
- R10: A completion and an accepted issue to a different slot in the same cycle both take effect.
- R11: A completion that names a free slot changes nothing.
- R12: With `iss_req`=0 nothing is recorded, whatever `iss_ok` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_req | input | 1 | Issue request for the presented instruction |
| iss_rd_vec | input | 9 | Read dependency vector (bits 0..7 fields, bit 8 whole register) |
| iss_wr_vec | input | 9 | Write dependency vector (same layout) |
| iss_ok | output | 1 | Instruction may issue this cycle |
| iss_slot | output | 2 | Slot the instruction occupies if issued |
| cmp_valid | input | 1 | Completion pulse |
| cmp_slot | input | 2 | Slot that completes |

## Verification
The bench presents instructions whose vectors share only bit 8. A design that let the whole-register bit into the hazard check would refuse them and serialise every CR operation. It checks read-after-write and write-after-write overlaps separately, and checks that a recorded read-only instruction blocks nothing. A design that recorded read fields would refuse these legal overlaps.

It fills all four slots with disjoint fields, to catch a design that forgets the no-free-slot refusal. It then retires one slot while issuing to another in the same cycle, and checks afterwards that both changes landed. It retires an idle slot to show that the state stays unchanged. Finally, a pending whole-register write must block any field access.

// File: rtl/cr_hzd_pkg.sv
package cr_hzd_pkg;
    localparam int unsigned CR_FIELDS = 8;
    localparam int unsigned DEP_W     = CR_FIELDS + 1;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;
endpackage

// File: rtl/cr_hzd_slot.sv
module cr_hzd_slot
    import cr_hzd_pkg::*;
#(
    parameter int unsigned NFLD = CR_FIELDS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic            retire,
    input  logic [NFLD-1:0] wr_fld,
    output logic            held,
    output logic [NFLD-1:0] pend_fld
);
    slot_state_e     state_q, state_d;
    logic [NFLD-1:0] fld_q;

    // next-state logic: ALLOCATE and RETIRE transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (alloc)  state_d = SLOT_HELD;
            SLOT_HELD: if (retire) state_d = SLOT_FREE;
            default:               state_d = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            fld_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SLOT_FREE && alloc) fld_q <= wr_fld;
        end
    end

    // outputs
    always_comb begin
        held     = (state_q == SLOT_HELD);
        pend_fld = held ? fld_q : '0;
    end

    assert_alloc_free_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !held);
    assert_alloc_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> held && pend_fld == $past(wr_fld));
    assert_retire_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (held && retire) |=> !held);
    assert_idle_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && retire && !alloc) |=> !held);
endmodule

// File: rtl/cr_hzd_pick.sv
module cr_hzd_pick #(
    parameter int unsigned N     = 4,
    localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  held,
    output logic          any_free,
    output logic [IW-1:0] free_idx
);
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!held[i]) begin
                any_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cr_hzd_sb.sv
module cr_hzd_sb
    import cr_hzd_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    localparam int unsigned SW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int unsigned NFLD     = CR_FIELDS,
    localparam int unsigned VW       = DEP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_req,
    input  logic [VW-1:0] iss_rd_vec,
    input  logic [VW-1:0] iss_wr_vec,
    output logic          iss_ok,
    output logic [SW-1:0] iss_slot,
    input  logic          cmp_valid,
    input  logic [SW-1:0] cmp_slot
);
    logic [NUM_SLOTS-1:0] held, hit, alloc, retire;
    logic [NFLD-1:0]      pend_fld [NUM_SLOTS];
    logic [NFLD-1:0]      touch_fld;
    logic                 any_free;
    logic                 unused_whole;

    // bit 8 is a pass-through flag for the datapath, not a hazard source
    assign unused_whole = iss_rd_vec[NFLD] ^ iss_wr_vec[NFLD];
    assign touch_fld    = iss_rd_vec[NFLD-1:0] | iss_wr_vec[NFLD-1:0];

    cr_hzd_pick #(.N(NUM_SLOTS)) u_pick (
        .held     (held),
        .any_free (any_free),
        .free_idx (iss_slot)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign hit[g]    = |(touch_fld & pend_fld[g]);
        assign alloc[g]  = iss_req && iss_ok && (iss_slot == SW'(g));
        assign retire[g] = cmp_valid && (cmp_slot == SW'(g));

        cr_hzd_slot #(.NFLD(NFLD)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc[g]),
            .retire   (retire[g]),
            .wr_fld   (iss_wr_vec[NFLD-1:0]),
            .held     (held[g]),
            .pend_fld (pend_fld[g])
        );
    end

    assign iss_ok = any_free && !(|hit);

    // checking aids
    logic [NFLD-1:0] pend_union;
    logic [7:0]      pend_bits;
    always_comb begin
        pend_union = '0;
        pend_bits  = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            pend_union = pend_union | pend_fld[k];
            pend_bits  = pend_bits + 8'($countones(pend_fld[k]));
        end
    end

    assert_reset_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (held == '0));
    assert_full_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&held) |-> !iss_ok);
    assert_waw_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
        8'($countones(pend_union)) == pend_bits);
    assert_no_issue_without_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_req && !cmp_valid) |=> $stable(held));
endmodule

// File: tb/cr_hzd_sb_tb_top.sv
module cr_hzd_sb_tb_top;
    localparam logic [8:0] B8  = 9'h100;
    localparam logic [8:0] ALL = 9'h1FF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_req = 1'b0;
    logic [8:0] iss_rd_vec = '0, iss_wr_vec = '0;
    logic       iss_ok;
    logic [1:0] iss_slot;
    logic       cmp_valid = 1'b0;
    logic [1:0] cmp_slot = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic       ok;
        logic [1:0] slot;
        bit         chk_slot;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    event smp;

    always #4 clk = ~clk;

    cr_hzd_sb dut_i (
        .clk(clk), .rst_n(rst_n), .iss_req(iss_req),
        .iss_rd_vec(iss_rd_vec), .iss_wr_vec(iss_wr_vec),
        .iss_ok(iss_ok), .iss_slot(iss_slot),
        .cmp_valid(cmp_valid), .cmp_slot(cmp_slot)
    );

    function automatic logic [8:0] f(input int n);
        return 9'(1) << n;
    endfunction

    // monitor: pops expectations and compares after inputs settle
    initial begin
        forever begin
            @(smp);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (iss_ok !== e.ok || (e.chk_slot && iss_slot !== e.slot)) begin
                    errors++;
                    $display("FAIL %s: ok=%0b slot=%0d expected ok=%0b slot=%0d",
                             e.tag, iss_ok, iss_slot, e.ok, e.slot);
                end
            end
        end
    end

    // driver: one cycle of stimulus, optionally with an expectation
    task automatic step(input bit req, input logic [8:0] rd, input logic [8:0] wr,
                        input bit cv, input int cs, input bit chk,
                        input logic eok, input int eslot, input string tag);
        exp_t e;
        @(negedge clk);
        iss_req = req; iss_rd_vec = rd; iss_wr_vec = wr;
        cmp_valid = cv; cmp_slot = 2'(cs);
        if (chk) begin
            e.ok = eok; e.slot = 2'(eslot); e.chk_slot = eok; e.tag = tag;
            exp_q.push_back(e);
        end
        ->smp;
        #2;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 and R12: free after reset, probe without request
        step(0, f(0)|B8, f(1)|B8, 0, 0, 1, 1, 0, "R1 reset free");
        step(0, f(0)|B8, f(1)|B8, 0, 0, 1, 1, 0, "R12 no record without req");
        step(1, f(0)|B8, f(1)|B8, 0, 0, 1, 1, 0, "R7 first issue slot0");   // slot0 W:CR1
        step(0, f(1)|B8, f(2)|B8, 0, 0, 1, 0, 1, "R2 read after write");
        step(0, f(3)|B8, f(1)|B8, 0, 0, 1, 0, 1, "R3 write after write");
        step(1, f(2)|B8, f(3)|B8, 0, 0, 1, 1, 1, "R4 share only bit8");     // slot1 W:CR3
        step(1, f(4)|B8, B8,      0, 0, 1, 1, 2, "R6 read-only record");    // slot2 none
        step(0, f(5)|B8, f(4)|B8, 0, 0, 1, 1, 3, "R6 pending read no block");
        step(1, f(5)|B8, f(4)|B8, 0, 0, 1, 1, 3, "R7 fill slot3");          // slot3 W:CR4
        step(0, f(7)|B8, f(7)|B8, 0, 0, 1, 0, 0, "R8 full refuse");
        step(0, '0, '0, 1, 1, 1, 0, 0, "R8 still full during retire");
        step(0, f(3)|B8, f(3)|B8, 0, 0, 1, 1, 1, "R9 retired slot free");
        step(1, f(3)|B8, f(3)|B8, 1, 0, 1, 1, 1, "R10 issue with retire");  // slot1 W:CR3, slot0 freed
        step(0, f(1)|B8, f(1)|B8, 0, 0, 1, 1, 0, "R10 retire landed");
        step(0, f(3)|B8, B8,      0, 0, 1, 0, 0, "R10 issue landed");
        step(0, '0, '0, 1, 0, 0, 0, 0, "");                                // retire idle slot0
        step(0, f(3)|B8, B8,      0, 0, 1, 0, 0, "R11 idle retire keeps slot1");
        step(1, f(0)|B8, f(0)|B8, 0, 0, 1, 1, 0, "R11 slot0 still allocatable");
        step(0, f(7)|B8, f(7)|B8, 0, 0, 1, 0, 0, "R11 others still held");
        for (int k = 0; k < 4; k++) step(0, '0, '0, 1, k, 0, 0, 0, "");
        step(1, B8, ALL, 0, 0, 1, 1, 0, "R5 whole write issue");
        step(0, f(5)|B8, f(6)|B8, 0, 0, 1, 0, 1, "R5 whole write blocks");
        step(0, B8, B8, 0, 0, 1, 1, 1, "R4 bit8 alone no hazard");
        step(0, '0, '0, 0, 0, 0, 0, 0, "");
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule